// File: doc/BRIEF.md
# Command stream register decoder

This block sits behind a byte-wide transport and interprets a stream of command frames aimed at a video controller. The transport hands over one byte per cycle on a valid/ready handshake. Every frame opens with an escape byte, followed by an opcode byte. One opcode writes a single byte into an internal video register file. A second opcode carries a copy descriptor, which the block turns into a one-cycle request strobe with the parsed fields beside it. Bytes that break the framing are dropped, and the parser then hunts for the next escape byte.

A reserved register address acts as a lock. While the file is locked, register writes go only to shadow storage. When the file is unlocked, every shadowed value reaches the live outputs in the same clock edge, so a full mode change appears at once. The live file is presented as one flat vector. Two 24-bit frame-buffer base pointers and a colour-depth flag are also decoded from it. Carrying out the memory copy is left to the consumer of the strobe.

Top module: `cmd_stream_decoder`

## Requirements
- R1: After a synchronous reset every live register reads 0x00, the file is unlocked, copy_req is low and the copy fields are zero.
- R2: With the file unlocked, the frame 0xAF, 0x20, address A, data D with A below REG_COUNT sets live byte A (regs_live[A*8+:8]) to D on the clock edge that accepts D.
- R3: base16 is the 24-bit value of registers 0x20, 0x21, 0x22, with register 0x20 as the most significant byte.
- R4: base8 is the 24-bit value of registers 0x26, 0x27, 0x28, with register 0x26 as the most significant byte.
- R5: depth24 equals bit 0 of register 0x00: 0 selects 16 bpp and 1 selects 24 bpp.
- R6: Writing data 0x00 to address 0xFF locks the file. While it stays locked, register writes leave regs_live unchanged.
- R7: Writing data 0xFF to address 0xFF unlocks the file. Every value written while locked reaches regs_live on that same edge.
- R8: A byte in the prefix position other than 0xAF is discarded. An opcode byte other than 0x20 or 0x6A is discarded and the parser returns to the prefix search. The byte after a bad opcode is therefore examined as a prefix candidate.
- R9: The frame 0xAF, 0x6A, S2, S1, S0, N, D2, D1, D0 raises copy_req for exactly one cycle after D0 is accepted, with copy_src={S2,S1,S0}, copy_count=N and copy_dst={D2,D1,D0}. The frame changes no register.
- R10: A write to an address at or above REG_COUNT, other than 0xFF, changes no live or shadow register.
- R11: A write to address 0xFF with data other than 0x00 or 0xFF leaves the lock state unchanged. The lock state changes only through a lock-register write.
- R12: Bytes presented while in_valid is low are ignored, and a frame may be spread over cycles with idle gaps. in_ready is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Always ready to accept a byte |
| regs_live | output | REG_COUNT*8 | Live register file, byte A at bits A*8+7:A*8 |
| locked | output | 1 | File is locked, so writes go to shadow only |
| base16 | output | 24 | 16 bpp segment base pointer |
| base8 | output | 24 | 8 bpp segment base pointer |
| depth24 | output | 1 | Colour depth select, 1 means 24 bpp |
| copy_req | output | 1 | One-cycle copy request strobe |
| copy_src | output | 24 | Copy source address |
| copy_count | output | 8 | Copy pixel count |
| copy_dst | output | 24 | Copy destination address |

## Verification
The assertions take two things for granted. First, copy frames are at least nine bytes apart, so two copy strobes can never touch. Second, the stream does not change the lock state except through writes to address 0xFF. Both follow from the framing itself, since the bench only emits whole or deliberately broken frames through a single byte-send task. That task holds in_valid for exactly one cycle per byte. Gaps appear only where the bench drives a valid-low cycle on purpose, and then in_data carries escape-like garbage so that any leak of unqualified bytes would show.

// File: rtl/cmd_stream_pkg.sv
package cmd_stream_pkg;

    localparam logic [7:0] ESC_BYTE    = 8'hAF;
    localparam logic [7:0] OPC_REGWR   = 8'h20;
    localparam logic [7:0] OPC_COPY    = 8'h6A;
    localparam logic [7:0] LOCK_ADDR   = 8'hFF;
    localparam logic [7:0] LOCK_VAL    = 8'h00;
    localparam logic [7:0] UNLOCK_VAL  = 8'hFF;
    localparam int         COPY_ARGS   = 7;
    localparam int         PTR_BYTES   = 3;
    localparam int         BASE16_ADDR = 32;
    localparam int         BASE8_ADDR  = 38;
    localparam int         DEPTH_ADDR  = 0;

    typedef enum logic [2:0] {
        ST_PREFIX,
        ST_OPCODE,
        ST_WADDR,
        ST_WDATA,
        ST_COPY
    } parse_state_e;

endpackage

// File: rtl/cmd_parser.sv
module cmd_parser
    import cmd_stream_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    output logic        wr_stb,
    output logic [7:0]  wr_addr,
    output logic [7:0]  wr_data,
    output logic        copy_req,
    output logic [23:0] copy_src,
    output logic [7:0]  copy_count,
    output logic [23:0] copy_dst
);

    localparam int ARG_W = (COPY_ARGS - 1) * 8;

    typedef struct packed {
        parse_state_e     state;
        logic [2:0]       idx;
        logic [ARG_W-1:0] args;
        logic [7:0]       addr;
        logic             req;
        logic [23:0]      src;
        logic [7:0]       cnt;
        logic [23:0]      dst;
    } parse_t;

    parse_t q, d;
    logic [ARG_W+7:0] full_desc;

    assign full_desc = {q.args, in_data};

    always_comb begin
        d     = q;
        d.req = 1'b0;
        if (in_valid) begin
            unique case (q.state)
                ST_PREFIX: begin
                    if (in_data == ESC_BYTE) d.state = ST_OPCODE;
                end
                ST_OPCODE: begin
                    if (in_data == OPC_REGWR) begin
                        d.state = ST_WADDR;
                    end else if (in_data == OPC_COPY) begin
                        d.state = ST_COPY;
                        d.idx   = '0;
                    end else begin
                        d.state = ST_PREFIX;
                    end
                end
                ST_WADDR: begin
                    d.addr  = in_data;
                    d.state = ST_WDATA;
                end
                ST_WDATA: begin
                    d.state = ST_PREFIX;
                end
                ST_COPY: begin
                    if (int'(q.idx) == COPY_ARGS - 1) begin
                        d.req   = 1'b1;
                        d.src   = full_desc[55:32];
                        d.cnt   = full_desc[31:24];
                        d.dst   = full_desc[23:0];
                        d.state = ST_PREFIX;
                        d.idx   = '0;
                    end else begin
                        d.args = {q.args[ARG_W-9:0], in_data};
                        d.idx  = q.idx + 3'd1;
                    end
                end
                default: d.state = ST_PREFIX;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{state: ST_PREFIX, default: '0};
        end else begin
            q <= d;
        end
    end

    assign wr_stb     = in_valid && (q.state == ST_WDATA);
    assign wr_addr    = q.addr;
    assign wr_data    = in_data;
    assign copy_req   = q.req;
    assign copy_src   = q.src;
    assign copy_count = q.cnt;
    assign copy_dst   = q.dst;

endmodule

// File: rtl/video_reg_bank.sv
module video_reg_bank
    import cmd_stream_pkg::*;
#(
    parameter int REG_COUNT = 48
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_stb,
    input  logic [7:0]                wr_addr,
    input  logic [7:0]                wr_data,
    output logic [REG_COUNT-1:0][7:0] live,
    output logic                      locked
);

    typedef struct packed {
        logic                      locked;
        logic [REG_COUNT-1:0][7:0] live;
        logic [REG_COUNT-1:0][7:0] shadow;
    } bank_t;

    bank_t q, d;
    logic  in_range;

    assign in_range = int'(wr_addr) < REG_COUNT;

    always_comb begin
        d = q;
        if (wr_stb) begin
            if (wr_addr == LOCK_ADDR) begin
                if (wr_data == LOCK_VAL) begin
                    d.locked = 1'b1;
                end else if (wr_data == UNLOCK_VAL) begin
                    d.locked = 1'b0;
                    d.live   = q.shadow;
                end
            end else if (in_range) begin
                d.shadow[wr_addr] = wr_data;
                if (!q.locked) d.live[wr_addr] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign live   = q.live;
    assign locked = q.locked;

endmodule

// File: rtl/reg_ptr_extract.sv
module reg_ptr_extract #(
    parameter int REG_COUNT = 48,
    parameter int BASE      = 32,
    parameter int BYTES     = 3
) (
    input  logic [REG_COUNT-1:0][7:0] live,
    output logic [BYTES*8-1:0]        ptr
);

    for (genvar i = 0; i < BYTES; i++) begin : g_byte
        assign ptr[(BYTES-1-i)*8 +: 8] = live[BASE+i];
    end

endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder
    import cmd_stream_pkg::*;
#(
    parameter int REG_COUNT = 48
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [7:0]             in_data,
    output logic                   in_ready,
    output logic [REG_COUNT*8-1:0] regs_live,
    output logic                   locked,
    output logic [23:0]            base16,
    output logic [23:0]            base8,
    output logic                   depth24,
    output logic                   copy_req,
    output logic [23:0]            copy_src,
    output logic [7:0]             copy_count,
    output logic [23:0]            copy_dst
);

    localparam int PTR_W = PTR_BYTES * 8;

    logic                      wr_stb;
    logic [7:0]                wr_addr;
    logic [7:0]                wr_data;
    logic [REG_COUNT-1:0][7:0] live_arr;
    logic [PTR_W-1:0]          ptr16;
    logic [PTR_W-1:0]          ptr8;

    assign in_ready = 1'b1;

    cmd_parser u_parser (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .wr_stb     (wr_stb),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .copy_req   (copy_req),
        .copy_src   (copy_src),
        .copy_count (copy_count),
        .copy_dst   (copy_dst)
    );

    video_reg_bank #(.REG_COUNT(REG_COUNT)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .live    (live_arr),
        .locked  (locked)
    );

    reg_ptr_extract #(.REG_COUNT(REG_COUNT), .BASE(BASE16_ADDR), .BYTES(PTR_BYTES)) u_ptr16 (
        .live (live_arr),
        .ptr  (ptr16)
    );

    reg_ptr_extract #(.REG_COUNT(REG_COUNT), .BASE(BASE8_ADDR), .BYTES(PTR_BYTES)) u_ptr8 (
        .live (live_arr),
        .ptr  (ptr8)
    );

    assign regs_live = live_arr;
    assign base16    = ptr16;
    assign base8     = ptr8;
    assign depth24   = live_arr[DEPTH_ADDR][0];

endmodule

// File: rtl/cmd_stream_decoder_chk.sv
module cmd_stream_decoder_chk #(
    parameter int REG_COUNT = 48
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_valid,
    input logic                   wr_stb,
    input logic                   locked,
    input logic [REG_COUNT*8-1:0] regs_live,
    input logic                   copy_req
);

    logic prev_rst_q = 1'b0;

    always_ff @(posedge clk) begin
        prev_rst_q <= rst;
    end

    // R1: state seen right after a reset edge
    always @(negedge clk) begin
        if (prev_rst_q && rst) begin
            assert_reset_state_R1: assert (regs_live == '0 && !locked && !copy_req)
                else $error("reset state wrong");
        end
    end

    assert_locked_live_stable_R6: assert property (@(posedge clk) disable iff (rst)
        locked |=> (!locked || $stable(regs_live)));

    assert_copy_single_R9: assert property (@(posedge clk) disable iff (rst)
        copy_req |=> !copy_req);

    assert_copy_after_byte_R9: assert property (@(posedge clk) disable iff (rst)
        copy_req |-> $past(in_valid));

    assert_lock_only_by_write_R11: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(locked));

endmodule

bind cmd_stream_decoder cmd_stream_decoder_chk #(.REG_COUNT(REG_COUNT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .wr_stb    (wr_stb),
    .locked    (locked),
    .regs_live (regs_live),
    .copy_req  (copy_req)
);

// File: tb/cmd_stream_decoder_tb.sv
`timescale 1ns/1ps
module cmd_stream_decoder_tb;

    localparam int RC = 48;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [7:0]    in_data;
    logic          in_ready;
    logic [RC*8-1:0] regs_live;
    logic          locked;
    logic [23:0]   base16, base8;
    logic          depth24;
    logic          copy_req;
    logic [23:0]   copy_src, copy_dst;
    logic [7:0]    copy_count;

    int checks = 0;
    int fails  = 0;

    logic [RC*8-1:0] exp_live;
    logic [RC*8-1:0] exp_shad;
    logic            exp_lock;

    always #4 clk = ~clk;

    cmd_stream_decoder #(.REG_COUNT(RC)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .regs_live(regs_live), .locked(locked),
        .base16(base16), .base8(base8), .depth24(depth24),
        .copy_req(copy_req), .copy_src(copy_src), .copy_count(copy_count),
        .copy_dst(copy_dst)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_file(input string req);
        checks++;
        if (regs_live !== exp_live || locked !== exp_lock) begin
            fails++;
            $display("FAIL %s actual=%h lock=%b expected=%h lock=%b", req, regs_live, locked, exp_live, exp_lock);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        in_data  = b;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic gap();
        in_data  = 8'hAF;
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    // model of a register write
    task automatic model_wr(input logic [7:0] a, input logic [7:0] v);
        if (a == 8'hFF) begin
            if (v == 8'h00) exp_lock = 1'b1;
            else if (v == 8'hFF) begin
                exp_lock = 1'b0;
                exp_live = exp_shad;
            end
        end else if (int'(a) < RC) begin
            exp_shad[a*8 +: 8] = v;
            if (!exp_lock) exp_live[a*8 +: 8] = v;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        send_byte(8'hAF);
        send_byte(8'h20);
        send_byte(a);
        send_byte(v);
        model_wr(a, v);
    endtask

    task automatic copy_frame(input logic [23:0] s, input logic [7:0] n, input logic [23:0] t, input string req);
        send_byte(8'hAF);
        send_byte(8'h6A);
        send_byte(s[23:16]); send_byte(s[15:8]); send_byte(s[7:0]);
        send_byte(n);
        send_byte(t[23:16]); send_byte(t[15:8]); send_byte(t[7:0]);
        check(copy_req === 1'b1, req, 64'(copy_req), 64'd1);
        check(copy_src === s, req, 64'(copy_src), 64'(s));
        check(copy_count === n, req, 64'(copy_count), 64'(n));
        check(copy_dst === t, req, 64'(copy_dst), 64'(t));
        @(negedge clk);
        check(copy_req === 1'b0, req, 64'(copy_req), 64'd0);
        check_file(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        in_valid = 1'b0;
        in_data  = 8'h00;
        rst      = 1'b1;
        exp_live = '0;
        exp_shad = '0;
        exp_lock = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check_file("R1");
        check(copy_req === 1'b0 && copy_src === 24'd0 && copy_count === 8'd0 && copy_dst === 24'd0,
              "R1", 64'(copy_req), 64'd0);
        check(in_ready === 1'b1, "R12", 64'(in_ready), 64'd1);

        // R2 unlocked sweep over every address
        for (int a = 0; a < RC; a++) begin
            wr(8'(a), 8'(a * 5 + 1));
            check_file("R2");
        end

        // R3 R4 R5 derived fields
        wr(8'h20, 8'h12); wr(8'h21, 8'h34); wr(8'h22, 8'h56);
        check(base16 === 24'h123456, "R3", 64'(base16), 64'h123456);
        wr(8'h26, 8'hAB); wr(8'h27, 8'hCD); wr(8'h28, 8'hEF);
        check(base8 === 24'hABCDEF, "R4", 64'(base8), 64'hABCDEF);
        wr(8'h00, 8'h01);
        check(depth24 === 1'b1, "R5", 64'(depth24), 64'd1);
        wr(8'h00, 8'h00);
        check(depth24 === 1'b0, "R5", 64'(depth24), 64'd0);

        // R6 locked sweep, live must hold
        wr(8'hFF, 8'h00);
        check(locked === 1'b1, "R6", 64'(locked), 64'd1);
        for (int a = 0; a < RC; a++) begin
            wr(8'(a), 8'(8'hC0 ^ 8'(a * 3)));
            check_file("R6");
        end
        // R11 odd lock value while locked
        wr(8'hFF, 8'h12);
        check(locked === 1'b1, "R11", 64'(locked), 64'd1);
        // R7 unlock commits everything at once
        wr(8'hFF, 8'hFF);
        check_file("R7");
        check(base16 === {8'(8'hC0 ^ 8'(32*3)), 8'(8'hC0 ^ 8'(33*3)), 8'(8'hC0 ^ 8'(34*3))},
              "R7", 64'(base16), 64'd0);

        // R11 odd lock value while unlocked
        wr(8'hFF, 8'h5A);
        check(locked === 1'b0, "R11", 64'(locked), 64'd0);
        check_file("R11");

        // R10 out of range addresses
        wr(8'(RC), 8'h99);
        wr(8'hFE, 8'h98);
        check_file("R10");
        wr(8'hFF, 8'h00);
        wr(8'hFF, 8'hFF);
        check_file("R10");

        // R8 bad prefix bytes discarded
        send_byte(8'h20); send_byte(8'h01); send_byte(8'h77);
        check_file("R8");
        // R8 bad opcode, following bytes treated as prefix search
        send_byte(8'hAF); send_byte(8'h55); send_byte(8'h20); send_byte(8'h01); send_byte(8'h77);
        check_file("R8");
        // R8 escape right after bad opcode starts a frame
        send_byte(8'hAF); send_byte(8'h55);
        wr(8'h01, 8'h77);
        check_file("R8");

        // R12 frame spread over idle gaps
        send_byte(8'hAF); gap(); gap();
        send_byte(8'h20); gap();
        send_byte(8'h02); gap(); gap(); gap();
        send_byte(8'h99);
        model_wr(8'h02, 8'h99);
        check_file("R12");
        repeat (4) gap();
        check_file("R12");

        // R9 copy descriptors
        copy_frame(24'h000000, 8'h01, 24'h000000, "R9");
        copy_frame(24'h123456, 8'hFE, 24'hABCDEF, "R9");
        wr(8'hFF, 8'h00);
        copy_frame(24'hFFFFFF, 8'h80, 24'h010203, "R9");
        wr(8'hFF, 8'hFF);
        check_file("R9");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule